// File: doc/BRIEF.md
# Walking-Pattern Memory Test Engine

This block runs a walking-pattern self-test on a window of a single-port synchronous RAM. It finds cells whose bits are stuck, and cells that disturb one another. The window is set by a base address and a length, both sampled when the test starts. A large memory can therefore be checked one segment at a time, which keeps each run short. The test has two passes. Pass 0 uses an all-zeros background and pass 1 uses an all-ones background, so a walking ones test is followed by a walking zeros test.

Each pass runs as follows. The engine first writes the background into every cell of the window. It then takes one victim cell at a time in ascending order and runs four steps on it. First it writes the complement of the background into the victim. Next it reads the whole window and checks that the victim holds the complement while every other cell still holds the background. It then writes the background back into the victim. Finally it reads the whole window again and expects the background everywhere.

Reads are pipelined, so the engine compares one word per clock. It stops at the first mismatch. It then reports the failing address, the data it expected, the data it read, and which pass was running.

Top module: `walkpat_engine`

## Requirements
- R1: While idle (busy_o low), a start_i pulse with a nonzero len_i is accepted. busy_o is high from the next cycle and done_o is cleared. A start_i pulse while busy_o is high is ignored and does not change the access sequence.
- R2: Every RAM access of a run addresses the window that was sampled at start, which is base_i up to base_i+len_i-1, modulo the address width. A clean run issues exactly the accesses listed in R3.
- R3: Each pass writes its background to the window cells in ascending order. Then, for each victim cell in ascending order, it issues:
  - one write of the complement to the victim;
  - a read of every window cell in ascending order, expecting the complement at the victim and the background elsewhere;
  - one write of the background to the victim;
  - a second ascending read of every window cell, expecting the background.
- R4: Pass 0 uses background 0x00 and is followed by pass 1 with background 0xFF. A clean run keeps busy_o high for exactly 2*(L + L*(2L+2)) + 1 cycles, where L is the window length.
- R5: Read data is taken from mem_rdata_i one cycle after the read request. One word is compared per clock. we is never raised without req.
- R6: On the first mismatching read, the engine stops. done_o and fail_o rise together, and fail_addr_o, fail_exp_o, fail_act_o and fail_pass_o (0 or 1) hold that read's address, expected word, read word and pass. These results and fail_o stay stable with no RAM access until the next accepted start.
- R7: A run with no mismatch ends with done_o high, busy_o low and fail_o low.
- R8: A start with len_i equal to zero makes done_o high in the next cycle, with fail_o low and no RAM access.
- R9: After reset, busy_o, done_o, fail_o and mem_req_o are all low.
- R10: Every word the engine writes is either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | AW | First address of the test window |
| len_i | input | AW | Number of cells in the window |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, held until next start |
| fail_o | output | 1 | A mismatch was found |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_exp_o | output | DW | Expected word at the first mismatch |
| fail_act_o | output | DW | Word read at the first mismatch |
| fail_pass_o | output | 1 | Pass of the first mismatch (0 = zeros background) |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after a read |

## Verification
Some properties are checked by assertions on every cycle:
- every access stays inside the window captured at start;
- written words are uniform;
- no access happens while idle or done;
- fail_o is never set without done_o;
- the reported result is frozen until restart;
- zero-length and nonzero starts have their next-cycle effects.

Other behaviour can only be shown by the bench's runs against a RAM model with injected stuck-at and coupling faults. This covers the exact order of writes and reads, the cycle count of a full two-pass run, and that the first failing address, data and pass match a model that walks the requirements.

// File: rtl/walkpat_pkg.sv
package walkpat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_INV,
    ST_SCAN1,
    ST_RST,
    ST_SCAN2,
    ST_DRAIN
  } wp_state_e;
endpackage

// File: rtl/walkpat_seq.sv
module walkpat_seq
  import walkpat_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic          halt_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] exp_o,
  output logic          pass_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  wp_state_e     state_q;
  logic [AW-1:0] base_q, len_q, idx_q, cur_q;
  logic          pass_q, done_q;
  logic [DW-1:0] bg;
  logic          idle, idx_last, cur_last;

  assign bg       = {DW{pass_q}};
  assign idle     = (state_q == ST_IDLE);
  assign idx_last = (idx_q == len_q - ONE);
  assign cur_last = (cur_q == len_q - ONE);
  assign accept_o = start_i & idle;
  assign busy_o   = ~idle;
  assign done_o   = done_q;
  assign pass_o   = pass_q;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = base_q + idx_q;
    wdata_o = bg;
    exp_o   = bg;
    case (state_q)
      ST_FILL: begin
        req_o = 1'b1;
        we_o  = 1'b1;
      end
      ST_INV: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = base_q + cur_q;
        wdata_o = ~bg;
      end
      ST_SCAN1: begin
        req_o = 1'b1;
        exp_o = (idx_q == cur_q) ? ~bg : bg;
      end
      ST_RST: begin
        req_o  = 1'b1;
        we_o   = 1'b1;
        addr_o = base_q + cur_q;
      end
      ST_SCAN2: req_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      cur_q   <= '0;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (halt_i && !idle) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q <= base_i;
            len_q  <= len_i;
            idx_q  <= '0;
            cur_q  <= '0;
            pass_q <= 1'b0;
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (idx_last) begin
            idx_q   <= '0;
            cur_q   <= '0;
            state_q <= ST_INV;
          end else begin
            idx_q <= idx_q + ONE;
          end
        end
        ST_INV: state_q <= ST_SCAN1;
        ST_SCAN1: begin
          if (idx_last) begin
            idx_q   <= '0;
            state_q <= ST_RST;
          end else begin
            idx_q <= idx_q + ONE;
          end
        end
        ST_RST: state_q <= ST_SCAN2;
        ST_SCAN2: begin
          if (idx_last) begin
            idx_q <= '0;
            if (!cur_last) begin
              cur_q   <= cur_q + ONE;
              state_q <= ST_INV;
            end else if (pass_q) begin
              state_q <= ST_DRAIN;
            end else begin
              pass_q  <= 1'b1;
              state_q <= ST_FILL;
            end
          end else begin
            idx_q <= idx_q + ONE;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/walkpat_cmp.sv
module walkpat_cmp #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] rd_exp_i,
  input  logic          rd_pass_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mismatch_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_exp_o,
  output logic [DW-1:0] fail_act_o,
  output logic          fail_pass_o
);
  // tag of the read in flight, aligned with rdata_i
  logic          vld_q, pass_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          fail_q;

  assign mismatch_o = vld_q & ~fail_q & ~clr_i & (rdata_i != exp_q);
  assign fail_o     = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      vld_q  <= rd_i;
      addr_q <= rd_addr_i;
      exp_q  <= rd_exp_i;
      pass_q <= rd_pass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
      fail_pass_o <= 1'b0;
    end else if (clr_i) begin
      fail_q      <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
      fail_pass_o <= 1'b0;
    end else if (mismatch_o) begin
      fail_q      <= 1'b1;
      fail_addr_o <= addr_q;
      fail_exp_o  <= exp_q;
      fail_act_o  <= rdata_i;
      fail_pass_o <= pass_q;
    end
  end
endmodule

// File: rtl/walkpat_engine.sv
module walkpat_engine #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_exp_o,
  output logic [DW-1:0] fail_act_o,
  output logic          fail_pass_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          accept, mismatch, rd_pass;
  logic [DW-1:0] rd_exp;

  walkpat_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .base_i   (base_i),
    .len_i    (len_i),
    .halt_i   (mismatch),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o),
    .exp_o    (rd_exp),
    .pass_o   (rd_pass)
  );

  walkpat_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .rd_i        (mem_req_o & ~mem_we_o),
    .rd_addr_i   (mem_addr_o),
    .rd_exp_i    (rd_exp),
    .rd_pass_i   (rd_pass),
    .rdata_i     (mem_rdata_i),
    .mismatch_o  (mismatch),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_act_o  (fail_act_o),
    .fail_pass_o (fail_pass_o)
  );
endmodule

// File: rtl/walkpat_chk.sv
module walkpat_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] len_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [DW-1:0] fail_act_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);
  logic [AW-1:0] cap_base, cap_len, off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_base <= '0;
      cap_len  <= '0;
    end else if (start_i && !busy_o) begin
      cap_base <= base_i;
      cap_len  <= len_i;
    end
  end

  assign off = mem_addr_o - cap_base;

  p_start_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i != '0) |=> (busy_o && !done_o));

  p_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (off < cap_len));

  p_we_has_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  p_fail_implies_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);

  p_quiet_when_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_req_o && !busy_o));

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(fail_o) && $stable(fail_addr_o) && $stable(fail_act_o)));

  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i == '0) |=> (done_o && !busy_o && !fail_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  p_uniform_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));
endmodule

bind walkpat_engine walkpat_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .base_i      (base_i),
  .len_i       (len_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .fail_act_o  (fail_act_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/tb_walkpat_engine.sv
`timescale 1ns/1ps
module tb_walkpat_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] base_i = '0, len_i = '0;
  logic       busy_o, done_o, fail_o, fail_pass_o;
  logic [7:0] fail_addr_o, fail_exp_o, fail_act_o;
  logic       mem_req_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o;
  logic [7:0] mem_rdata_i = '0;

  int n_chk = 0, n_bad = 0;

  // fault configuration
  logic       sa_en = 1'b0, cf_en = 1'b0;
  logic [7:0] sa_addr = '0, sa_mask = '0, sa_val = '0;
  logic [7:0] cf_agg = '0, cf_vic = '0;
  logic [2:0] cf_bit = '0;

  logic [7:0] ram  [0:255];
  logic [7:0] refm [0:255];

  // expected access log and reference outcome
  logic       e_we [0:1023];
  logic [7:0] e_addr [0:1023];
  logic [7:0] e_wd [0:1023];
  int         n_exp;
  logic       found;
  logic [7:0] r_addr, r_exp, r_act;
  logic       r_pass;

  always #5 clk_i = ~clk_i;

  walkpat_engine #(.AW(8), .DW(8)) dut (.*);

  function automatic logic [7:0] stored(input logic [7:0] a, input logic [7:0] d);
    if (sa_en && a == sa_addr) return (d & ~sa_mask) | (sa_val & sa_mask);
    return d;
  endfunction

  // RAM model: one-cycle read latency; all-ones write to aggressor clears a victim bit
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        ram[mem_addr_o] <= stored(mem_addr_o, mem_wdata_o);
        if (cf_en && mem_addr_o == cf_agg && mem_wdata_o == 8'hFF)
          ram[cf_vic][cf_bit] <= 1'b0;
      end else begin
        mem_rdata_i <= ram[mem_addr_o];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ref_wr(input logic [7:0] a, input logic [7:0] d);
    if (found) return;
    e_we[n_exp] = 1'b1; e_addr[n_exp] = a; e_wd[n_exp] = d; n_exp++;
    refm[a] = stored(a, d);
    if (cf_en && a == cf_agg && d == 8'hFF) refm[cf_vic][cf_bit] = 1'b0;
  endtask

  task automatic ref_rd(input logic [7:0] a, input logic [7:0] e, input logic p);
    if (found) return;
    e_we[n_exp] = 1'b0; e_addr[n_exp] = a; e_wd[n_exp] = '0; n_exp++;
    if (refm[a] != e) begin
      found = 1'b1; r_addr = a; r_exp = e; r_act = refm[a]; r_pass = p;
    end
  endtask

  // model of the R3/R4 procedure
  task automatic ref_run(input logic [7:0] b, input int len);
    logic [7:0] bg;
    found = 1'b0; n_exp = 0;
    for (int i = 0; i < 256; i++) refm[i] = ram[i];
    for (int p = 0; p < 2; p++) begin
      bg = (p == 1) ? 8'hFF : 8'h00;
      for (int i = 0; i < len; i++) ref_wr(b + 8'(i), bg);
      for (int c = 0; c < len; c++) begin
        ref_wr(b + 8'(c), ~bg);
        for (int j = 0; j < len; j++) ref_rd(b + 8'(j), (j == c) ? ~bg : bg, p[0]);
        ref_wr(b + 8'(c), bg);
        for (int j = 0; j < len; j++) ref_rd(b + 8'(j), bg, p[0]);
      end
    end
  endtask

  task automatic run_test(input logic [7:0] b, input logic [7:0] l, input int inj, input string tag);
    int cyc = 0, busy_cnt = 0, n_act = 0, seq_err = -1, bad_w = 0, li;
    li = int'(l);
    ref_run(b, li);
    @(negedge clk_i);
    base_i = b; len_i = l; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && cyc < 5000) begin
      if (busy_o) busy_cnt++;
      if (mem_req_o) begin
        if (mem_we_o && mem_wdata_o != 8'h00 && mem_wdata_o != 8'hFF) bad_w++;
        if (n_act < n_exp && seq_err < 0) begin
          if (mem_we_o != e_we[n_act] || mem_addr_o != e_addr[n_act] ||
              (mem_we_o && mem_wdata_o != e_wd[n_act])) seq_err = n_act;
        end
        n_act++;
      end
      if (cyc == inj) begin
        start_i = 1'b1; base_i = b + 8'd5; len_i = 8'd2;
      end else begin
        start_i = 1'b0;
      end
      cyc++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(cyc < 5000, "R7", {tag, " run completes"}, cyc, 5000);
    chk(seq_err < 0, "R3", {tag, " access order index"}, seq_err, -1);
    chk(bad_w == 0, "R10", {tag, " non-uniform writes"}, bad_w, 0);
    if (inj >= 0) chk(seq_err < 0 && !fail_o, "R1", {tag, " start while busy ignored"}, seq_err, -1);
    if (!found) begin
      chk(fail_o == 1'b0 && done_o && !busy_o, "R7", {tag, " clean result"}, int'(fail_o), 0);
      chk(n_act == n_exp, "R2", {tag, " access count"}, n_act, n_exp);
      chk(busy_cnt == 2 * (li + li * (2 * li + 2)) + 1, "R4", {tag, " busy cycles"},
          busy_cnt, 2 * (li + li * (2 * li + 2)) + 1);
    end else begin
      chk(fail_o == 1'b1, "R6", {tag, " fail flag"}, int'(fail_o), 1);
      chk(fail_addr_o == r_addr, "R6", {tag, " fail addr"}, int'(fail_addr_o), int'(r_addr));
      chk(fail_exp_o == r_exp, "R6", {tag, " fail expected"}, int'(fail_exp_o), int'(r_exp));
      chk(fail_act_o == r_act, "R5", {tag, " fail actual"}, int'(fail_act_o), int'(r_act));
      chk(fail_pass_o == r_pass, "R4", {tag, " fail pass"}, int'(fail_pass_o), int'(r_pass));
    end
  endtask

  task automatic clear_faults();
    sa_en = 1'b0; cf_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] l, b, a1, a2;
    int kind, o1, o2;
    int quiet_req;
    logic [7:0] held_addr;
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(!busy_o && !done_o && !fail_o && !mem_req_o, "R9", "reset outputs",
        int'({busy_o, done_o, fail_o, mem_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_test(8'h10, 8'd4, -1, "directed len4");
    run_test(8'hFF, 8'd1, -1, "directed single cell");
    run_test(8'h40, 8'd6, 7, "start while busy");

    // R8: zero length
    @(negedge clk_i);
    base_i = 8'h20; len_i = 8'd0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && !busy_o && !fail_o && !mem_req_o, "R8", "zero length done",
        int'({done_o, busy_o, fail_o, mem_req_o}), 8);

    // stuck-at-1 bit (pass 0 expected)
    sa_en = 1'b1; sa_addr = 8'h33; sa_mask = 8'h04; sa_val = 8'hFF;
    run_test(8'h30, 8'd5, -1, "stuck-at-1");
    // R6: result held, no access afterwards
    quiet_req = 0; held_addr = fail_addr_o;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (mem_req_o) quiet_req++;
    end
    chk(quiet_req == 0 && done_o && fail_o && fail_addr_o == held_addr, "R6", "result held after fail",
        quiet_req, 0);
    clear_faults();

    // stuck-at-0 bit
    sa_en = 1'b1; sa_addr = 8'h52; sa_mask = 8'h80; sa_val = 8'h00;
    run_test(8'h50, 8'd3, -1, "stuck-at-0");
    clear_faults();

    // coupling: only visible with ones background (pass 1)
    cf_en = 1'b1; cf_agg = 8'h63; cf_vic = 8'h61; cf_bit = 3'd5;
    run_test(8'h60, 8'd4, -1, "coupling");
    chk(fail_pass_o == 1'b1, "R4", "coupling seen in pass 1", int'(fail_pass_o), 1);
    clear_faults();

    // constrained random runs
    for (int k = 0; k < 10; k++) begin
      l = 8'(1 + $urandom % 8);
      b = 8'($urandom % (257 - int'(l)));
      kind = int'($urandom % 3);
      clear_faults();
      if (kind == 1) begin
        sa_en = 1'b1; sa_addr = b + 8'($urandom % l);
        sa_mask = 8'(1 << ($urandom % 8)); sa_val = 8'($urandom);
      end else if (kind == 2 && l >= 8'd2) begin
        o1 = int'($urandom % l);
        o2 = (o1 + 1 + int'($urandom % (l - 8'd1))) % int'(l);
        a1 = b + 8'(o1); a2 = b + 8'(o2);
        cf_en = 1'b1; cf_agg = a1; cf_vic = a2; cf_bit = 3'($urandom);
      end
      run_test(b, l, -1, $sformatf("random %0d", k));
    end
    clear_faults();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule